// File: doc/BRIEF.md
# Segmented Configuration Chain Loader

This block fills one segment of an FPGA's configuration storage from a narrow on-chip network port. Each packet starts with a header beat that gives the number of payload beats. The loader then takes the payload beats one at a time and shifts each of them, one bit per cycle, into a local shift-register segment whose contents drive the configuration outputs in parallel. Many loaders can sit side by side, one per segment. Each fills its own segment without regard to the others, so the segments are programmed in parallel.

A segment's shift register is clocked only while its own bits are arriving. At all other times it holds its value and nothing in it toggles. The shift enable and the configuration clear each pass through the same number of register stages before they reach the chain, so the two stay in order across hierarchy levels. A completion flag tells the surrounding logic when the segment's last bit has landed.

Top module: `cfg_seg_loader`

## Requirements
- R1: While the asynchronous reset is held, and after it is released, `cfg_bits` is all zeros, `load_done` is 0 and `bs_ready` is 1.
- R2: The first beat accepted while waiting for a packet is a header. Its value, an unsigned count of BEAT_W bits, is the number of payload beats that follow.
- R3: Each payload beat is shifted into the chain LSB first, one bit per cycle over BEAT_W cycles. On every shift the new bit enters `cfg_bits[CHAIN_BITS-1]` and every other bit moves down one index. With CHAIN_BITS=16 and two 8-bit payload beats p0 then p1, the chain ends as {p1, p0}.
- R4: Counting the first cycle after the edge that accepts a payload beat as cycle 1, `bs_ready` is 0 in cycles 1 to BEAT_W and 1 in cycle BEAT_W+1.
- R5: Counting the same way from the acceptance of the last payload beat, with BEAT_W=8: the chain holds its final value in cycle 9+CTL_STAGES, `load_done` is still 0 in that cycle, and `load_done` is 1 in cycle 10+CTL_STAGES. This is one cycle after the last bit is shifted in.
- R6: `load_done` stays 1 until a new header is accepted, and it is 0 in the first cycle after that acceptance.
- R7: A header of value 0 leaves the chain untouched. `bs_ready` is 0 in cycle 1 after the header. `load_done` is 0 in cycle 2+CTL_STAGES and 1 in cycle 3+CTL_STAGES.
- R8: A packet shorter than the chain moves the older contents toward index 0. In a packet longer than the chain, the earliest bits fall off at index 0.
- R9: A one-cycle `cfg_rst` pulse passes through CTL_STAGES register stages. In cycle CTL_STAGES+1 after the pulse, the chain is all zeros, `load_done` is 0 and `bs_ready` is 1. Any load in progress is dropped, and no shift from it reaches the chain afterwards.
- R10: In every cycle in which no bit is being shifted and no clear is applied, `cfg_bits` keeps its value.
- R11: A beat held on `bs_data` with `bs_valid` high while `bs_ready` is 0 is not consumed. It is taken, unchanged, at the first edge at which `bs_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rst | input | 1 | Synchronous configuration clear, registered before use |
| bs_valid | input | 1 | Beat valid from the network port |
| bs_data | input | BEAT_W | Header or payload beat |
| bs_ready | output | 1 | Loader can take a beat this cycle |
| cfg_bits | output | CHAIN_BITS | Parallel view of the segment's configuration bits |
| load_done | output | 1 | Segment loaded since the last header |

## Verification
The bench builds the loader with a 16-bit chain, 8-bit beats and two control stages. In this configuration two payload beats exactly fill the segment, so every one of the 256 beat values can be swept through a complete packet and compared against an arithmetic shift model. The short chain also makes it cheap to check the cases where bits fall off the end (one-beat and three-beat packets). The two control stages separate the effect of the pipelined clear and enable from the serializer timing, which exposes any off-by-one in the timing of done, ready and reset.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [1:0] {
    SER_HDR   = 2'd0,
    SER_LOAD  = 2'd1,
    SER_SHIFT = 2'd2,
    SER_MARK  = 2'd3
  } ser_state_e;

  typedef struct packed {
    logic en;
    logic dat;
    logic last;
  } shift_cmd_t;

endpackage

// File: rtl/cfg_ctl_pipe.sv
module cfg_ctl_pipe
  import cfg_loader_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_rst_i,
  input  shift_cmd_t cmd_i,
  output logic       rst_o,
  output shift_cmd_t cmd_o
);

  logic       rst_r [STAGES];
  logic       rst_d [STAGES];
  shift_cmd_t cmd_r [STAGES];
  shift_cmd_t cmd_d [STAGES];

  assign rst_o = rst_r[STAGES-1];
  assign cmd_o = cmd_r[STAGES-1];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign rst_d[k] = cfg_rst_i;
      assign cmd_d[k] = rst_o ? '0 : cmd_i;
    end else begin : g_tail
      assign rst_d[k] = rst_r[k-1];
      assign cmd_d[k] = rst_o ? '0 : cmd_r[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) begin
        rst_r[k] <= 1'b0;
        cmd_r[k] <= '0;
      end
    end else begin
      for (int k = 0; k < STAGES; k++) begin
        rst_r[k] <= rst_d[k];
        cmd_r[k] <= cmd_d[k];
      end
    end
  end

endmodule

// File: rtl/cfg_beat_ser.sv
module cfg_beat_ser
  import cfg_loader_pkg::*;
#(
  parameter int BEAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              in_valid,
  input  logic [BEAT_W-1:0] in_data,
  output logic              in_ready,
  output logic              hdr_take_o,
  output shift_cmd_t        cmd_o
);

  localparam int CNT_W = (BEAT_W > 1) ? $clog2(BEAT_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BEAT_W - 1);

  ser_state_e        st_q, st_n;
  logic [BEAT_W-1:0] sh_q, sh_n;
  logic [BEAT_W-1:0] left_q, left_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              take;

  assign in_ready   = ((st_q == SER_HDR) || (st_q == SER_LOAD)) && !clr_i;
  assign take       = in_valid && in_ready;
  assign hdr_take_o = take && (st_q == SER_HDR);

  always_comb begin
    st_n   = st_q;
    sh_n   = sh_q;
    left_n = left_q;
    cnt_n  = cnt_q;
    unique case (st_q)
      SER_HDR: begin
        if (take) begin
          left_n = in_data;
          st_n   = (in_data == '0) ? SER_MARK : SER_LOAD;
        end
      end
      SER_LOAD: begin
        if (take) begin
          sh_n   = in_data;
          cnt_n  = '0;
          left_n = left_q - BEAT_W'(1);
          st_n   = SER_SHIFT;
        end
      end
      SER_SHIFT: begin
        sh_n  = sh_q >> 1;
        cnt_n = cnt_q + CNT_W'(1);
        if (cnt_q == CNT_LAST) begin
          st_n = (left_q == '0) ? SER_HDR : SER_LOAD;
        end
      end
      SER_MARK: st_n = SER_HDR;
      default:  st_n = SER_HDR;
    endcase
    if (clr_i) begin
      st_n = SER_HDR;
    end
  end

  always_comb begin
    cmd_o.en   = (st_q == SER_SHIFT);
    cmd_o.dat  = sh_q[0];
    cmd_o.last = ((st_q == SER_SHIFT) && (cnt_q == CNT_LAST) && (left_q == '0))
              || (st_q == SER_MARK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SER_HDR;
      sh_q   <= '0;
      left_q <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_n;
      sh_q   <= sh_n;
      left_q <= left_n;
      cnt_q  <= cnt_n;
    end
  end

  // R3: an accepted payload beat starts shifting in the next cycle
  p_shift_follows_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (st_q == SER_LOAD) && !clr_i) |=> cmd_o.en);

  // R4: ready drops right after a payload beat is taken
  p_ready_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (st_q == SER_LOAD) && !clr_i) |=> !in_ready);

  // R7: an empty header raises the completion marker with no shift
  p_empty_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_take_o && (in_data == '0) && !clr_i) |=> (cmd_o.last && !cmd_o.en));

endmodule

// File: rtl/cfg_chain_seg.sv
module cfg_chain_seg
  import cfg_loader_pkg::*;
#(
  parameter int CHAIN_BITS = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  shift_cmd_t            cmd_i,
  output logic [CHAIN_BITS-1:0] bits_o
);

  logic [CHAIN_BITS-1:0] chain_q, chain_n;
  logic                  chain_ce;

  assign chain_ce = clr_i || cmd_i.en;

  always_comb begin
    if (clr_i) begin
      chain_n = '0;
    end else if (CHAIN_BITS > 1) begin
      chain_n = {cmd_i.dat, chain_q[CHAIN_BITS-1:1]};
    end else begin
      chain_n = CHAIN_BITS'(cmd_i.dat);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else if (chain_ce) begin
      chain_q <= chain_n;
    end
  end

  assign bits_o = chain_q;

  // R9: a clear empties the segment
  p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (bits_o == '0));

  // R10: no enable, no clear -> no switching
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !cmd_i.en) |=> $stable(bits_o));

  // R3: the shifted-in bit appears at the top of the chain
  p_enter_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && cmd_i.en) |=> (bits_o[CHAIN_BITS-1] == $past(cmd_i.dat)));

endmodule

// File: rtl/cfg_seg_loader.sv
module cfg_seg_loader
  import cfg_loader_pkg::*;
#(
  parameter int BEAT_W     = 8,
  parameter int CHAIN_BITS = 64,
  parameter int CTL_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_rst,
  input  logic                  bs_valid,
  input  logic [BEAT_W-1:0]     bs_data,
  output logic                  bs_ready,
  output logic [CHAIN_BITS-1:0] cfg_bits,
  output logic                  load_done
);

  shift_cmd_t ser_cmd, chain_cmd;
  logic       rst_q;
  logic       hdr_take;
  logic       fin_q, fin_n;
  logic       done_q, done_n;

  cfg_beat_ser #(.BEAT_W(BEAT_W)) u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (rst_q),
    .in_valid   (bs_valid),
    .in_data    (bs_data),
    .in_ready   (bs_ready),
    .hdr_take_o (hdr_take),
    .cmd_o      (ser_cmd)
  );

  cfg_ctl_pipe #(.STAGES(CTL_STAGES)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rst_i (cfg_rst),
    .cmd_i     (ser_cmd),
    .rst_o     (rst_q),
    .cmd_o     (chain_cmd)
  );

  cfg_chain_seg #(.CHAIN_BITS(CHAIN_BITS)) u_chain (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (rst_q),
    .cmd_i  (chain_cmd),
    .bits_o (cfg_bits)
  );

  always_comb begin
    fin_n  = !rst_q && chain_cmd.last;
    done_n = done_q;
    if (rst_q || hdr_take) begin
      done_n = 1'b0;
    end else if (fin_q) begin
      done_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      fin_q  <= fin_n;
      done_q <= done_n;
    end
  end

  assign load_done = done_q;

  // R5: done rises two cycles after the final command reaches the chain
  p_done_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_done) |-> $past(chain_cmd.last, 2));

  // R6: accepting a header drops done
  p_done_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_take |=> !load_done);

  // R9: registered clear drops done
  p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> !load_done);

endmodule

// File: tb/cfg_seg_loader_tb_top.sv
module cfg_seg_loader_tb_top;

  localparam int BW = 8;
  localparam int NB = 16;
  localparam int S  = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_rst;
  logic          bs_valid;
  logic [BW-1:0] bs_data;
  logic          bs_ready;
  logic [NB-1:0] cfg_bits;
  logic          load_done;

  int checks = 0;
  int errors = 0;
  logic [NB-1:0] model;

  always #5 clk = ~clk;

  cfg_seg_loader #(.BEAT_W(BW), .CHAIN_BITS(NB), .CTL_STAGES(S)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rst   (cfg_rst),
    .bs_valid  (bs_valid),
    .bs_data   (bs_data),
    .bs_ready  (bs_ready),
    .cfg_bits  (cfg_bits),
    .load_done (load_done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] push(input logic [NB-1:0] m, input logic [BW-1:0] b);
    logic [NB-1:0] r = m;
    for (int i = 0; i < BW; i++) r = {b[i], r[NB-1:1]};
    return r;
  endfunction

  // returns at cycle 1 after the header is accepted
  task automatic send_hdr(input logic [BW-1:0] n);
    bs_valid = 1'b1;
    bs_data  = n;
    while (!bs_ready) @(negedge clk);
    @(negedge clk);
    bs_valid = 1'b0;
  endtask

  // returns at cycle BW+1 after the beat is accepted, checking ready (R4)
  task automatic send_pay(input logic [BW-1:0] b);
    bs_valid = 1'b1;
    bs_data  = b;
    while (!bs_ready) @(negedge clk);
    @(negedge clk);
    bs_valid = 1'b0;
    model = push(model, b);
    for (int c = 1; c <= BW; c++) begin
      if (c > 1) @(negedge clk);
      chk("R4 ready low while serializing", bs_ready, 1'b0);
    end
    @(negedge clk);
    chk("R4 ready back after beat", bs_ready, 1'b1);
  endtask

  // called at cycle 9 after the last payload beat (R5)
  task automatic finish_pkt(input string req);
    repeat (S) @(negedge clk);
    chk(req, cfg_bits, model);
    chk("R5 done still low at final shift", load_done, 1'b0);
    @(negedge clk);
    chk("R5 done high one cycle later", load_done, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [NB-1:0] snap;
    rst_n    = 1'b0;
    cfg_rst  = 1'b0;
    bs_valid = 1'b0;
    bs_data  = '0;
    model    = '0;
    repeat (3) @(negedge clk);
    chk("R1 bits in reset", cfg_bits, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 bits after reset", cfg_bits, '0);
    chk("R1 done after reset", load_done, 1'b0);
    chk("R1 ready after reset", bs_ready, 1'b1);

    // R2 R3: full sweep of beat values through two-beat packets
    for (int v = 0; v < 256; v++) begin
      send_hdr(8'd2);
      chk("R6 done cleared by header", load_done, 1'b0);
      send_pay(BW'(v));
      send_pay(BW'(v) ^ 8'hA5);
      finish_pkt("R3 two-beat packet fills chain");
      chk("R3 packing {p1,p0}", cfg_bits, {BW'(v) ^ 8'hA5, BW'(v)});
      repeat (4) @(negedge clk);
      chk("R6 done holds until next header", load_done, 1'b1);
    end

    // R7: empty header
    snap = cfg_bits;
    send_hdr(8'd0);
    chk("R7 ready low after empty header", bs_ready, 1'b0);
    chk("R6 done cleared by empty header", load_done, 1'b0);
    repeat (S + 1) @(negedge clk);
    chk("R7 done low at 2+S", load_done, 1'b0);
    @(negedge clk);
    chk("R7 done high at 3+S", load_done, 1'b1);
    chk("R7 chain untouched", cfg_bits, snap);

    // R8: short and long packets
    send_hdr(8'd1);
    send_pay(8'h3C);
    finish_pkt("R8 short packet shifts old bits down");
    chk("R8 short value", cfg_bits, {8'h3C, snap[15:8]});
    send_hdr(8'd3);
    send_pay(8'h11);
    send_pay(8'h22);
    send_pay(8'h33);
    finish_pkt("R8 long packet drops earliest bits");
    chk("R8 long value", cfg_bits, 16'h3322);

    // R10: idle segment holds
    snap = cfg_bits;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (c % 10 == 9) chk("R10 idle chain stable", cfg_bits, snap);
    end

    // R11: beat held while not ready is taken later unchanged
    send_hdr(8'd2);
    bs_valid = 1'b1;
    bs_data  = 8'hC7;
    while (!bs_ready) @(negedge clk);
    @(negedge clk);
    bs_data  = 8'h5E;
    model = push(push(model, 8'hC7), 8'h5E);
    @(negedge clk);
    chk("R11 held beat not taken while busy", bs_ready, 1'b0);
    while (!bs_ready) @(negedge clk);
    @(negedge clk);
    bs_valid = 1'b0;
    repeat (8) @(negedge clk);
    finish_pkt("R11 held beat loaded");
    chk("R11 value", cfg_bits, 16'h5EC7);

    // R9: clear in the middle of a load
    send_hdr(8'd2);
    bs_valid = 1'b1;
    bs_data  = 8'hFF;
    while (!bs_ready) @(negedge clk);
    @(negedge clk);
    bs_valid = 1'b0;
    @(negedge clk);
    cfg_rst = 1'b1;
    @(negedge clk);
    cfg_rst = 1'b0;
    repeat (S) @(negedge clk);
    chk("R9 chain cleared", cfg_bits, '0);
    chk("R9 done cleared", load_done, 1'b0);
    chk("R9 ready after clear", bs_ready, 1'b1);
    repeat (30) @(negedge clk);
    chk("R9 no leftover shifts", cfg_bits, '0);
    chk("R9 no done from dropped load", load_done, 1'b0);
    model = '0;
    send_hdr(8'd2);
    send_pay(8'h81);
    send_pay(8'h42);
    finish_pkt("R9 load after clear");
    chk("R9 reload value", cfg_bits, 16'h4281);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule